// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block is a register-mapped controller in front of a small one-time-programmable fuse array. The array is a set of banks, each holding 256 rows of eight fuses. Software loads a 16-bit fuse address through two byte registers and then writes a command code to a control register. A sense command reads the whole addressed row into a sense-data register. A program command blows the single addressed fuse bit. Fuses only ever go from 0 to 1.

Programming is guarded by a key register. A program command succeeds only while that register holds the unlock key. Otherwise the command leaves the array alone and raises a protection error. Every operation that finishes raises a done flag in a status register. Every refused operation raises an error flag. Both registers are write-one-to-clear, and each has its own mask register. The masked flags are combined into one registered interrupt. The fuse array is behavioural: a plain row memory with a synchronous read, written so that it maps onto block RAM.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: The address-high register (offset 5) holds fuse address bits 15:8 and the address-low register (offset 6) holds bits 7:0. Both read back as written. The bank is address bits 15:11, the row is bits 10:3 and the bit index is bits 2:0.
- R3: Writing 0x08 to the control register (offset 4) senses the addressed row. SENSE_CYCLES or more cycles later, the row byte is readable at the sense-data register (offset 7) and status bit 0 is set.
- R4: Writing 0x31 to the control register while the key register (offset 8) holds 0xAA sets the addressed fuse bit in the array and then sets status bit 1.
- R5: A program command while the key register holds any value other than 0xAA leaves the array unchanged, sets error bit 1, and does not set status bit 1.
- R6: Programming ORs one bit into the row. Other bits of the row keep their values. Programming a bit that is already set leaves it set.
- R7: The status register (offset 0, bits 1:0) and the error register (offset 2, bits 7:1) are write-one-to-clear. A written 0 leaves a flag unchanged, and error bit 0 always reads 0.
- R8: `irq` is set one cycle after any status bit is set with its bit set in the status-mask register (offset 1, bits 1:0), or any error bit is set with its bit set in the error-mask register (offset 3, bits 7:1). With both masks zero, `irq` stays low.
- R9: A command written while an operation is in progress is ignored. It does not program, sense or flag anything.
- R10: A command whose bank field is not below 2^BANK_BITS sets error bit 2, touches no row, and sets no status bit.
- R11: A control-register value other than 0x08 or 0x31 starts nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the next edge |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered, masked interrupt |

## Verification
Most errors inside the sequencer leave a lasting mark in the array. A wrong row or bit index, a missing OR with the old row, or a write that skips the key check shows up on the next sense of that row, as a wrong byte in the sense-data register. The bench therefore follows every program with a sense of the same row and of a neighbouring bank. A stuck or restarted busy state shows up within a few dozen cycles: a done flag is missing, or a flag appears that the ignored command should not have raised. Broken flag or mask logic shows on `irq` one cycle after the flag changes.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [3:0] OFS_STS   = 4'd0;
  localparam logic [3:0] OFS_SMSK  = 4'd1;
  localparam logic [3:0] OFS_ERR   = 4'd2;
  localparam logic [3:0] OFS_EMSK  = 4'd3;
  localparam logic [3:0] OFS_CTRL  = 4'd4;
  localparam logic [3:0] OFS_ADRH  = 4'd5;
  localparam logic [3:0] OFS_ADRL  = 4'd6;
  localparam logic [3:0] OFS_SDAT  = 4'd7;
  localparam logic [3:0] OFS_KEY   = 4'd8;

  localparam logic [7:0] CMD_SENSE = 8'h08;
  localparam logic [7:0] CMD_PROG  = 8'h31;
  localparam logic [7:0] UNLOCK    = 8'hAA;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SENSE, SQ_PROG} seq_state_t;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int ROW_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              we,
  input  logic [ROW_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data
);
  localparam int DEPTH = 1 << ROW_AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // R6: a write may only add ones to the stored row
  assert_one_way_R6: assert property (@(posedge clk) disable iff (rst)
    we |-> ((mem[wr_addr] & ~wr_data) == 8'h00));
endmodule

// File: rtl/otp_sequencer.sv
module otp_sequencer
  import otp_pkg::*;
#(
  parameter int SENSE_CYCLES = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int BANK_BITS    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_sense,
  input  logic                  go_prog,
  input  logic                  key_ok,
  input  logic [15:0]           fuse_addr,
  output logic [BANK_BITS+7:0]  mem_raddr,
  input  logic [7:0]            mem_rdata,
  output logic                  mem_we,
  output logic [BANK_BITS+7:0]  mem_waddr,
  output logic [7:0]            mem_wdata,
  output logic                  busy,
  output logic                  sense_done,
  output logic                  prog_done,
  output logic                  lock_fault,
  output logic                  range_fault,
  output logic [7:0]            sense_value
);
  localparam int ROW_AW    = BANK_BITS + 8;
  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int MAXC      = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;
  localparam int CNT_W     = $clog2(MAXC + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_AW-1:0] row_q;
  logic [2:0]        bit_q;
  logic              in_range;
  logic [ROW_AW-1:0] row_idx;

  assign in_range = {1'b0, fuse_addr[15:11]} < 6'(NUM_BANKS);
  assign row_idx  = {fuse_addr[11 +: BANK_BITS], fuse_addr[10:3]};

  assign busy      = (state != SQ_IDLE);
  assign mem_raddr = row_q;
  assign mem_waddr = row_q;
  assign mem_we    = (state == SQ_PROG) && (cnt == '0);
  assign mem_wdata = mem_rdata | (8'h01 << bit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      cnt         <= '0;
      row_q       <= '0;
      bit_q       <= '0;
      sense_value <= '0;
      sense_done  <= 1'b0;
      prog_done   <= 1'b0;
      lock_fault  <= 1'b0;
      range_fault <= 1'b0;
    end else begin
      sense_done  <= 1'b0;
      prog_done   <= 1'b0;
      lock_fault  <= 1'b0;
      range_fault <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (go_sense || go_prog) begin
            if (!in_range) begin
              range_fault <= 1'b1;
            end else if (go_prog && !key_ok) begin
              lock_fault <= 1'b1;
            end else begin
              state <= go_prog ? SQ_PROG : SQ_SENSE;
              cnt   <= go_prog ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(SENSE_CYCLES - 1);
              row_q <= row_idx;
              bit_q <= fuse_addr[2:0];
            end
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            state <= SQ_IDLE;
            if (state == SQ_SENSE) begin
              sense_value <= mem_rdata;
              sense_done  <= 1'b1;
            end else begin
              prog_done <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R9: an operation in progress is neither restarted nor switched
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && cnt != '0) |=> (state == $past(state)));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int SENSE_CYCLES = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int BANK_BITS    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int ROW_AW = BANK_BITS + 8;

  logic [1:0] sts_q, smask_q;
  logic [7:0] err_q, emask_q;
  logic [7:0] adrh_q, adrl_q, key_q;
  logic       go_sense, go_prog, key_ok, seq_busy;
  logic       sense_done, prog_done, lock_fault, range_fault;
  logic [7:0] sense_value;
  logic [ROW_AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rdata, mem_wdata;
  logic       mem_we;
  logic       wr_sts, wr_err;

  assign go_sense = reg_wr && (reg_addr == OFS_CTRL) && (reg_wdata == CMD_SENSE);
  assign go_prog  = reg_wr && (reg_addr == OFS_CTRL) && (reg_wdata == CMD_PROG);
  assign key_ok   = (key_q == UNLOCK);
  assign wr_sts   = reg_wr && (reg_addr == OFS_STS);
  assign wr_err   = reg_wr && (reg_addr == OFS_ERR);

  otp_sequencer #(
    .SENSE_CYCLES(SENSE_CYCLES),
    .PROG_CYCLES (PROG_CYCLES),
    .BANK_BITS   (BANK_BITS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go_sense   (go_sense),
    .go_prog    (go_prog),
    .key_ok     (key_ok),
    .fuse_addr  ({adrh_q, adrl_q}),
    .mem_raddr  (mem_raddr),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .busy       (seq_busy),
    .sense_done (sense_done),
    .prog_done  (prog_done),
    .lock_fault (lock_fault),
    .range_fault(range_fault),
    .sense_value(sense_value)
  );

  otp_fuse_array #(.ROW_AW(ROW_AW)) u_array (
    .clk    (clk),
    .rst    (rst),
    .rd_addr(mem_raddr),
    .rd_data(mem_rdata),
    .we     (mem_we),
    .wr_addr(mem_waddr),
    .wr_data(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      smask_q <= '0;
      err_q   <= '0;
      emask_q <= '0;
      adrh_q  <= '0;
      adrl_q  <= '0;
      key_q   <= '0;
      irq     <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~(wr_sts ? reg_wdata[1:0] : 2'b00)) | {prog_done, sense_done};
      err_q <= ((err_q & ~(wr_err ? reg_wdata : 8'h00)) |
                {5'b0, range_fault, lock_fault, 1'b0}) & 8'hFE;
      if (reg_wr) begin
        case (reg_addr)
          OFS_SMSK: smask_q <= reg_wdata[1:0];
          OFS_EMSK: emask_q <= reg_wdata & 8'hFE;
          OFS_ADRH: adrh_q  <= reg_wdata;
          OFS_ADRL: adrl_q  <= reg_wdata;
          OFS_KEY:  key_q   <= reg_wdata;
          default: ;
        endcase
      end
      irq <= (|(sts_q & smask_q)) || (|(err_q & emask_q));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_STS:  reg_rdata <= {6'b0, sts_q};
        OFS_SMSK: reg_rdata <= {6'b0, smask_q};
        OFS_ERR:  reg_rdata <= err_q;
        OFS_EMSK: reg_rdata <= emask_q;
        OFS_ADRH: reg_rdata <= adrh_q;
        OFS_ADRL: reg_rdata <= adrl_q;
        OFS_SDAT: reg_rdata <= sense_value;
        OFS_KEY:  reg_rdata <= key_q;
        default:  reg_rdata <= 8'h00;
      endcase
    end
  end

  // R5: a locked program command never starts the sequencer
  assert_locked_no_start_R5: assert property (@(posedge clk) disable iff (rst)
    (go_prog && !key_ok && !seq_busy) |=> !seq_busy);

  // R7: writing one to status bit 0 clears it unless a sense finishes then
  assert_sts_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && reg_wdata[0] && !sense_done) |=> !sts_q[0]);

  // R8: with both masks clear the interrupt stays low
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (smask_q == 2'b00 && emask_q == 8'h00) |=> !irq);
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  otp_fuse_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // vector: {kind[1:0] (0 sense, 1 program), fuse address[15:0], expected sense byte[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd1, 16'h002A, 8'h00},
    {2'd0, 16'h0028, 8'h04},
    {2'd1, 16'h1FFF, 8'h00},
    {2'd0, 16'h1FF8, 8'h80},
    {2'd1, 16'h002A, 8'h00},
    {2'd0, 16'h0028, 8'h04},
    {2'd1, 16'h0028, 8'h00},
    {2'd0, 16'h0828, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_sts(input logic [1:0] m);
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rd(4'd0, s);
      if ((s[1:0] & m) != 2'b00) return;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [1:0] kind;
    logic [15:0] fa;
    logic [7:0]  ex;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    // R2: address registers read back
    wr(4'd5, 8'h1F); wr(4'd6, 8'hF8);
    rd(4'd5, v); check("R2 address high", v, 8'h1F);
    rd(4'd6, v); check("R2 address low", v, 8'hF8);

    // R3: status not set right after the command
    wr(4'd4, 8'h08);
    rd(4'd0, v); check("R3 no early done", v, 8'h00);
    wait_sts(2'b01);
    rd(4'd7, v); check("R3 blank row", v, 8'h00);
    wr(4'd0, 8'h03);

    // table: R4 program, R6 one-way OR, R3 sense, R2 bank isolation
    for (int i = 0; i < 8; i++) begin
      {kind, fa, ex} = VEC[i];
      wr(4'd5, fa[15:8]); wr(4'd6, fa[7:0]);
      if (kind == 2'd1) begin
        wr(4'd8, 8'hAA);
        wr(4'd4, 8'h31);
        wait_sts(2'b10);
        rd(4'd0, v); check("R4 program done", v, 8'h02);
        rd(4'd2, v); check("R4 no error", v, 8'h00);
        wr(4'd8, 8'h00);
      end else begin
        wr(4'd4, 8'h08);
        wait_sts(2'b01);
        rd(4'd7, v); check("R6 sensed row", v, ex);
      end
      wr(4'd0, 8'h03);
    end

    // R5: locked program
    wr(4'd5, 8'h08); wr(4'd6, 8'h29);
    wr(4'd4, 8'h31);
    idle(15);
    rd(4'd2, v); check("R5 protect error", v, 8'h02);
    rd(4'd0, v); check("R5 no program done", v, 8'h00);
    wr(4'd6, 8'h28); wr(4'd4, 8'h08); wait_sts(2'b01);
    rd(4'd7, v); check("R5 row unchanged", v, 8'h00);
    // R7: write zero keeps, write one clears
    wr(4'd0, 8'h02);
    rd(4'd0, v); check("R7 zero write keeps status", v, 8'h01);
    wr(4'd0, 8'h01);
    rd(4'd0, v); check("R7 status cleared", v, 8'h00);
    wr(4'd2, 8'h01);
    rd(4'd2, v); check("R7 error bit0 write keeps", v, 8'h02);
    wr(4'd2, 8'hFE);
    rd(4'd2, v); check("R7 error cleared", v, 8'h00);

    // R10: bank out of range
    wr(4'd5, 8'h20); wr(4'd6, 8'h00);
    wr(4'd4, 8'h08);
    idle(10);
    rd(4'd2, v); check("R10 range error", v, 8'h04);
    rd(4'd0, v); check("R10 no done", v, 8'h00);
    wr(4'd2, 8'hFE);

    // R11: unknown control value
    wr(4'd5, 8'h00); wr(4'd6, 8'h28);
    wr(4'd4, 8'h55);
    idle(15);
    rd(4'd0, v); check("R11 no status", v, 8'h00);
    rd(4'd2, v); check("R11 no error", v, 8'h00);

    // R9: program during a sense is ignored (address bank0 row5 bit1)
    wr(4'd6, 8'h29);
    wr(4'd8, 8'hAA);
    wr(4'd4, 8'h08);
    wr(4'd4, 8'h31);
    wait_sts(2'b01);
    idle(20);
    rd(4'd0, v); check("R9 only sense done", v, 8'h01);
    rd(4'd7, v); check("R9 sense value", v, 8'h05);
    wr(4'd8, 8'h00);
    wr(4'd0, 8'h03);
    wr(4'd4, 8'h08); wait_sts(2'b01);
    rd(4'd7, v); check("R9 row not programmed", v, 8'h05);

    // R8: interrupt masking (sense status still set)
    idle(2);
    check("R8 masked irq low", {7'b0, irq}, 8'h00);
    wr(4'd1, 8'h01);
    idle(2);
    check("R8 status irq", {7'b0, irq}, 8'h01);
    wr(4'd0, 8'h01);
    idle(1);
    check("R8 irq drops after clear", {7'b0, irq}, 8'h00);
    wr(4'd3, 8'h02);
    wr(4'd4, 8'h31);
    idle(4);
    check("R8 error irq", {7'b0, irq}, 8'h01);
    wr(4'd3, 8'h00);
    idle(2);
    check("R8 error mask off", {7'b0, irq}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule